// File: doc/BRIEF.md
# Single-Channel DMA Transaction Controller

This block runs one DMA channel. A transfer can be started in two ways. Software can pulse a start input. Hardware can raise a request line, but only while the channel's hardware-enable flag is set. Either source marks a request as pending. When the channel is idle and its transfer count is not zero, the move engine takes the pending request.

Each transfer has two moves on a simple valid/ready bus-master port:

- a read from the source address, then
- a write of the returned data to the destination address.

Only one command is outstanding at a time. When a transfer completes, the count drops by one and both addresses step by their own signed increments, scaled by the transfer size.

When the count reaches zero, the block raises a one-cycle interrupt. In single mode it also switches off hardware triggering at that point. The block has three sticky error flags:

- a read error, which also skips the write but still advances the destination address;
- a write error;
- a request that arrives while an earlier one is still pending.

Top module: `dma_chan_ctrl`

## Requirements
- R1: A one-cycle pulse on `sw_start` sets `pending` at the next clock edge, whatever the state of `hw_en`. The engine then takes the request and performs one transfer.
- R2: `hw_en_set` turns `hw_en` on and `hw_en_clr` turns it off. While `hw_en` is 1, each cycle in which `hw_req` is high is one request. While `hw_en` is 0, `hw_req` has no effect: it sets neither `pending` nor the lost flag.
- R3: Each completed transfer lowers `tcount` by exactly one. `tcount` never wraps below zero. A pending request is not taken while `tcount` is 0.
- R4: When `cfg_cont_mode` is 0 (single mode), `hw_en` is cleared in the same clock edge at which `tcount` reaches 0. When `cfg_cont_mode` is 1, `hw_en` is left unchanged.
- R5: `irq` is high for exactly one cycle: the cycle after the edge at which the final transfer completes and `tcount` becomes 0. It is low at all other times.
- R6: A transfer first issues a read (`m_write`=0, `m_addr` = source address). It then issues a write (`m_write`=1, `m_addr` = destination address, `m_wdata` = the read data). `m_valid`, `m_write` and `m_addr` stay stable until `m_ready`.
- R7: After each transfer, each address adds its signed step multiplied by 2^SIZE_LOG2 (4 bytes by default), wrapping modulo 2^ADDR_W.
- R8: When a read completes with `m_err`=1, `err_flags[0]` becomes 1 and stays set. No write is issued. The destination address still advances, and the count still decrements.
- R9: When a write completes with `m_err`=1, `err_flags[1]` becomes 1 and stays set.
- R10: A request that arrives while `pending` is 1 and is not taken in that cycle sets `err_flags[2]`. A 1 in bit i of `err_clr` clears `err_flags[i]`. If a set and a clear of the same flag happen in one cycle, the set wins.
- R11: `cnt_load` loads `cnt_init`, `src_init` and `dst_init` only while `busy` is 0. While a transfer is in progress it is ignored. Reloading a channel whose count is 0 re-arms it, so a request still pending is then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cont_mode | input | 1 | 0 = single mode (auto-disable of hardware triggering), 1 = continuous |
| sw_start | input | 1 | Software request pulse |
| hw_en_set | input | 1 | Pulse: enable hardware requests |
| hw_en_clr | input | 1 | Pulse: disable hardware requests |
| hw_req | input | 1 | Hardware request line, one request per high cycle |
| cnt_load | input | 1 | Pulse: load count and both addresses (idle only) |
| cnt_init | input | CNT_W | Initial transfer count |
| src_init | input | ADDR_W | Initial source address |
| dst_init | input | ADDR_W | Initial destination address |
| src_step | input | STEP_W | Signed source step in transfer units |
| dst_step | input | STEP_W | Signed destination step in transfer units |
| err_clr | input | 3 | Write-1 clear: bit0 read error, bit1 write error, bit2 lost request |
| m_valid | output | 1 | Bus command valid |
| m_write | output | 1 | 1 = write move, 0 = read move |
| m_addr | output | ADDR_W | Bus address |
| m_wdata | output | DATA_W | Write data |
| m_ready | input | 1 | Command accepted and completed this cycle |
| m_err | input | 1 | Error response, valid with m_ready |
| m_rdata | input | DATA_W | Read data, valid with m_ready |
| hw_en | output | 1 | Hardware-enable flag |
| pending | output | 1 | Request waiting for service |
| busy | output | 1 | A transfer is in progress |
| tcount | output | CNT_W | Remaining transfer count |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| err_flags | output | 3 | Sticky flags: bit0 read error, bit1 write error, bit2 lost request |
| irq | output | 1 | End-of-transaction pulse |

## Verification
The in-line assertions check the properties that can be judged on every cycle:

- the bus command is held stable until accepted;
- the count stays at zero unless reloaded, and is frozen while a move is waiting;
- `irq` appears only with a zero count;
- no write follows a failed read;
- the sticky flags stay set;
- `hw_en` is never lost without a clear;
- the addresses do not drift while idle.

Other behaviour can only be shown by the bench's scenarios, where a transactional model predicts every bus command and every post-transfer state:

- the correct address sequence under signed steps;
- the write data being the read data;
- the single-mode auto-disable, compared with continuous mode;
- the lost-request detection;
- the busy-time reload being ignored;
- the re-arm after reload.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   typedef enum logic [1:0] {
      MV_IDLE  = 2'd0,
      MV_READ  = 2'd1,
      MV_WRITE = 2'd2
   } mv_state_e;

   localparam int FLAG_RD_ERR = 0;
   localparam int FLAG_WR_ERR = 1;
   localparam int FLAG_LOST   = 2;
   localparam int FLAG_N      = 3;

endpackage

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_start,
   input  logic hw_en_set,
   input  logic hw_en_clr,
   input  logic hw_req,
   input  logic auto_clr,
   input  logic take,
   output logic pending,
   output logic hw_en,
   output logic lost_evt
);

   logic pend_q, hw_en_q, req_evt;

   assign req_evt  = sw_start | (hw_req & hw_en_q);
   assign lost_evt = req_evt & pend_q & ~take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         hw_en_q <= 1'b0;
      end else begin
         if (req_evt)   pend_q <= 1'b1;
         else if (take) pend_q <= 1'b0;

         if (hw_en_set)                  hw_en_q <= 1'b1;
         else if (hw_en_clr || auto_clr) hw_en_q <= 1'b0;
      end
   end

   assign pending = pend_q;
   assign hw_en   = hw_en_q;

   // R2: a disabled request line leaves the pending flag untouched
   a_r2_req_ignored_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_en_q && hw_req && !sw_start && !pend_q) |=> !pend_q);

   // R4: the enable flag only drops through a software or end-of-transaction clear
   a_r4_enable_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hw_en_q) |-> $past(hw_en_clr || auto_clr));

   // R1: a software pulse always leaves a request pending
   a_r1_sw_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      sw_start |=> pend_q);

endmodule

// File: rtl/dma_err_flags.sv
module dma_err_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      f_q <= 1'b0;
         else if (set[i]) f_q <= 1'b1;
         else if (clr[i]) f_q <= 1'b0;
      end
      assign flags[i] = f_q;

      // R10: a raised flag stays until its clear bit is written
      a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (f_q && !clr[i]) |=> f_q);
   end

endmodule

// File: rtl/dma_addr_stepper.sv
module dma_addr_stepper #(
   parameter int ADDR_W    = 32,
   parameter int STEP_W    = 8,
   parameter int SIZE_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              adv,
   input  logic [STEP_W-1:0] step,
   output logic [ADDR_W-1:0] addr
);

   localparam int EXT_W = ADDR_W - STEP_W;

   logic [ADDR_W-1:0] addr_q, step_ext, step_bytes;

   assign step_ext   = {{EXT_W{step[STEP_W-1]}}, step};
   assign step_bytes = step_ext << SIZE_LOG2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= load_val;
      else if (adv)  addr_q <= addr_q + step_bytes;
   end

   assign addr = addr_q;

   // R7: the address only moves on a load or a completed transfer
   a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(addr_q));

endmodule

// File: rtl/dma_move_engine.sv
module dma_move_engine
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pending,
   input  logic              cont_mode,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   output logic              m_valid,
   output logic              m_write,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_wdata,
   input  logic              m_ready,
   input  logic              m_err,
   input  logic [DATA_W-1:0] m_rdata,
   output logic              take,
   output logic              load_ok,
   output logic              done,
   output logic              rd_err_evt,
   output logic              wr_err_evt,
   output logic              auto_clr,
   output logic [CNT_W-1:0]  tcount,
   output logic              irq,
   output logic              busy
);

   mv_state_e         state_q;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              irq_q, idle, cnt_zero, rd_hs, wr_hs, last;

   assign idle     = (state_q == MV_IDLE);
   assign cnt_zero = (cnt_q == '0);
   assign load_ok  = idle & cnt_load;
   assign take     = idle & pending & ~cnt_zero & ~cnt_load;

   assign rd_hs      = (state_q == MV_READ)  & m_ready;
   assign wr_hs      = (state_q == MV_WRITE) & m_ready;
   assign rd_err_evt = rd_hs & m_err;
   assign wr_err_evt = wr_hs & m_err;
   assign done       = rd_err_evt | wr_hs;
   assign last       = done & (cnt_q == CNT_W'(1));
   assign auto_clr   = last & ~cont_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MV_IDLE;
         data_q  <= '0;
      end else begin
         case (state_q)
            MV_IDLE:  if (take) state_q <= MV_READ;
            MV_READ:  if (m_ready) begin
                         if (m_err) state_q <= MV_IDLE;
                         else begin
                            data_q  <= m_rdata;
                            state_q <= MV_WRITE;
                         end
                      end
            MV_WRITE: if (m_ready) state_q <= MV_IDLE;
            default:  state_q <= MV_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= last;
         if (load_ok)                  cnt_q <= cnt_val;
         else if (done && !cnt_zero)   cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign m_valid = !idle;
   assign m_write = (state_q == MV_WRITE);
   assign m_addr  = m_write ? dst_addr : src_addr;
   assign m_wdata = data_q;
   assign tcount  = cnt_q;
   assign irq     = irq_q;
   assign busy    = !idle;

   // R6: an unaccepted command is held unchanged
   a_r6_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_write) && $stable(m_addr)));

   // R3: an exhausted count stays at zero until reloaded
   a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_zero && !load_ok) |=> (cnt_q == '0));

   // R11: the count is frozen while a move is waiting
   a_r11_count_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !done) |=> $stable(cnt_q));

   // R5: the interrupt only appears with an exhausted count
   a_r5_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> cnt_zero);

   // R8: a failed read is never followed by a write
   a_r8_skip_write: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err_evt |=> !m_write);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 8,
   parameter int STEP_W    = 8,
   parameter int SIZE_LOG2 = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cont_mode,
   input  logic                sw_start,
   input  logic                hw_en_set,
   input  logic                hw_en_clr,
   input  logic                hw_req,
   input  logic                cnt_load,
   input  logic [CNT_W-1:0]    cnt_init,
   input  logic [ADDR_W-1:0]   src_init,
   input  logic [ADDR_W-1:0]   dst_init,
   input  logic [STEP_W-1:0]   src_step,
   input  logic [STEP_W-1:0]   dst_step,
   input  logic [FLAG_N-1:0]   err_clr,
   output logic                m_valid,
   output logic                m_write,
   output logic [ADDR_W-1:0]   m_addr,
   output logic [DATA_W-1:0]   m_wdata,
   input  logic                m_ready,
   input  logic                m_err,
   input  logic [DATA_W-1:0]   m_rdata,
   output logic                hw_en,
   output logic                pending,
   output logic                busy,
   output logic [CNT_W-1:0]    tcount,
   output logic [ADDR_W-1:0]   src_addr,
   output logic [ADDR_W-1:0]   dst_addr,
   output logic [FLAG_N-1:0]   err_flags,
   output logic                irq
);

   localparam int NPTR = 2;

   initial begin
      a_param_step_fits: assert (ADDR_W > STEP_W) else $error("step wider than address");
      a_param_size_fits: assert (SIZE_LOG2 < ADDR_W) else $error("transfer size too large");
      a_param_cnt_width: assert (CNT_W >= 1) else $error("count width must be positive");
   end

   logic take, load_ok, done, rd_err_evt, wr_err_evt, auto_clr, lost_evt;
   logic [FLAG_N-1:0] flag_set;
   logic [ADDR_W-1:0] ptr_init [NPTR];
   logic [STEP_W-1:0] ptr_step [NPTR];
   logic [ADDR_W-1:0] ptr_addr [NPTR];

   dma_req_ctrl u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_start  (sw_start),
      .hw_en_set (hw_en_set),
      .hw_en_clr (hw_en_clr),
      .hw_req    (hw_req),
      .auto_clr  (auto_clr),
      .take      (take),
      .pending   (pending),
      .hw_en     (hw_en),
      .lost_evt  (lost_evt)
   );

   dma_move_engine #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .pending    (pending),
      .cont_mode  (cfg_cont_mode),
      .cnt_load   (cnt_load),
      .cnt_val    (cnt_init),
      .src_addr   (ptr_addr[0]),
      .dst_addr   (ptr_addr[1]),
      .m_valid    (m_valid),
      .m_write    (m_write),
      .m_addr     (m_addr),
      .m_wdata    (m_wdata),
      .m_ready    (m_ready),
      .m_err      (m_err),
      .m_rdata    (m_rdata),
      .take       (take),
      .load_ok    (load_ok),
      .done       (done),
      .rd_err_evt (rd_err_evt),
      .wr_err_evt (wr_err_evt),
      .auto_clr   (auto_clr),
      .tcount     (tcount),
      .irq        (irq),
      .busy       (busy)
   );

   assign ptr_init[0] = src_init;
   assign ptr_init[1] = dst_init;
   assign ptr_step[0] = src_step;
   assign ptr_step[1] = dst_step;

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      dma_addr_stepper #(
         .ADDR_W    (ADDR_W),
         .STEP_W    (STEP_W),
         .SIZE_LOG2 (SIZE_LOG2)
      ) u_step (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load_ok),
         .load_val (ptr_init[g]),
         .adv      (done),
         .step     (ptr_step[g]),
         .addr     (ptr_addr[g])
      );
   end

   assign src_addr = ptr_addr[0];
   assign dst_addr = ptr_addr[1];

   assign flag_set[FLAG_RD_ERR] = rd_err_evt;
   assign flag_set[FLAG_WR_ERR] = wr_err_evt;
   assign flag_set[FLAG_LOST]   = lost_evt;

   dma_err_flags #(.N(FLAG_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (err_clr),
      .flags (err_flags)
   );

   // R4: in single mode the enable flag is gone once the count has been used up
   a_r4_single_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cfg_cont_mode && !$past(hw_en_set) && !$past(cfg_cont_mode)) |-> !hw_en);

endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int CW = 8;
   localparam int SW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_cont_mode = 1'b0, sw_start = 1'b0, hw_en_set = 1'b0, hw_en_clr = 1'b0, hw_req = 1'b0;
   logic cnt_load = 1'b0;
   logic [CW-1:0] cnt_init = '0;
   logic [AW-1:0] src_init = '0, dst_init = '0;
   logic [SW-1:0] src_step = '0, dst_step = '0;
   logic [2:0] err_clr = '0;
   logic m_valid, m_write, m_ready = 1'b0, m_err = 1'b0;
   logic [AW-1:0] m_addr, src_addr, dst_addr;
   logic [DW-1:0] m_wdata, m_rdata;
   logic hw_en, pending, busy, irq;
   logic [CW-1:0] tcount;
   logic [2:0] err_flags;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_cont_mode(cfg_cont_mode), .sw_start(sw_start),
      .hw_en_set(hw_en_set), .hw_en_clr(hw_en_clr), .hw_req(hw_req), .cnt_load(cnt_load),
      .cnt_init(cnt_init), .src_init(src_init), .dst_init(dst_init), .src_step(src_step),
      .dst_step(dst_step), .err_clr(err_clr), .m_valid(m_valid), .m_write(m_write),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata),
      .hw_en(hw_en), .pending(pending), .busy(busy), .tcount(tcount), .src_addr(src_addr),
      .dst_addr(dst_addr), .err_flags(err_flags), .irq(irq)
   );

   int n_cmp = 0, n_bad = 0, n_irq = 0, n_wr = 0;
   int rdy_pct = 100, err_pct = 0;
   bit force_rd_err = 0, force_wr_err = 0;

   logic [AW-1:0] exp_src, exp_dst;
   logic [DW-1:0] exp_data;
   int exp_cnt = 0;
   bit exp_ph = 0, chk_due = 0, irq_exp = 0;
   logic [1:0] exp_ef = '0;

   function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
      return a ^ 32'h5A3C_0F96;
   endfunction

   function automatic logic [AW-1:0] step_bytes(input logic [SW-1:0] s);
      logic [AW-1:0] e;
      e = {{(AW-SW){s[SW-1]}}, s};
      return e << 2;
   endfunction

   assign m_rdata = mem_fn(m_addr);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // bus responder: decides ready and error just after each edge
   initial begin
      forever begin
         @(posedge clk); #1;
         m_ready = (($urandom % 100) < 32'(rdy_pct));
         m_err = m_ready && m_valid &&
                 ((!m_write && force_rd_err) || (m_write && force_wr_err) ||
                  (($urandom % 100) < 32'(err_pct)));
      end
   end

   // transactional monitor and reference model
   always @(negedge clk) begin
      if (rst_n) begin
         if (chk_due) begin
            chk(irq == irq_exp, "R5 irq at end of transaction", 64'(irq), 64'(irq_exp));
            chk(32'(tcount) == exp_cnt, "R3 count after transfer", 64'(tcount), 64'(exp_cnt));
            chk(src_addr == exp_src, "R7 source step", 64'(src_addr), 64'(exp_src));
            chk(dst_addr == exp_dst, "R7 destination step", 64'(dst_addr), 64'(exp_dst));
            chk(err_flags[1:0] == exp_ef, "R8 R9 error flags", 64'(err_flags[1:0]), 64'(exp_ef));
            chk_due = 0;
         end else if (irq) begin
            chk(1'b0, "R5 stray irq", 64'(irq), 64'd0);
         end
         if (irq) n_irq++;
         if (m_valid && m_ready) begin
            if (!exp_ph) begin
               chk(!m_write && m_addr == exp_src, "R6 read command", {31'd0, m_write, m_addr}, {32'd0, exp_src});
               if (m_err) begin
                  exp_ef[0] = 1'b1;
                  exp_src = exp_src + step_bytes(src_step);
                  exp_dst = exp_dst + step_bytes(dst_step);
                  exp_cnt--; irq_exp = (exp_cnt == 0); chk_due = 1;
               end else begin
                  exp_data = m_rdata; exp_ph = 1;
               end
            end else begin
               n_wr++;
               chk(m_write && m_addr == exp_dst, "R6 write command", {31'd0, m_write, m_addr}, {32'd1, exp_dst});
               chk(m_wdata == exp_data, "R6 write data", 64'(m_wdata), 64'(exp_data));
               if (m_err) exp_ef[1] = 1'b1;
               exp_src = exp_src + step_bytes(src_step);
               exp_dst = exp_dst + step_bytes(dst_step);
               exp_cnt--; irq_exp = (exp_cnt == 0); chk_due = 1; exp_ph = 0;
            end
         end
      end
   end

   task automatic report;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_sw;  sw_start = 1;  tick(1); sw_start = 0;  endtask
   task automatic pulse_req; hw_req = 1;    tick(1); hw_req = 0;    endtask
   task automatic pulse_en;  hw_en_set = 1; tick(1); hw_en_set = 0; endtask
   task automatic pulse_dis; hw_en_clr = 1; tick(1); hw_en_clr = 0; endtask

   task automatic clear_flags(input logic [2:0] m);
      err_clr = m; tick(1); err_clr = '0;
      exp_ef = exp_ef & ~m[1:0];
   endtask

   task automatic load(input int c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                       input logic [SW-1:0] ss, input logic [SW-1:0] ds);
      cnt_init = CW'(c); src_init = s; dst_init = d; src_step = ss; dst_step = ds;
      cnt_load = 1; tick(1); cnt_load = 0;
      exp_cnt = c; exp_src = s; exp_dst = d;
   endtask

   task automatic wait_idle;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (!busy && !pending) break;
      end
      @(negedge clk);
      tick(0);
   endtask

   initial begin
      tick(4);
      @(negedge clk);
      chk(tcount == 0 && hw_en == 0 && pending == 0 && !busy, "R3 reset state", 64'({tcount, hw_en, pending, busy}), 64'd0);
      chk(err_flags == 0 && irq == 0 && m_valid == 0, "R10 reset flags", 64'({err_flags, irq, m_valid}), 64'd0);
      rst_n = 1;
      tick(2);

      // R1: software start with hardware disabled
      load(3, 32'h1000, 32'h2000, 8'd1, 8'hFE);
      pulse_sw();
      @(negedge clk);
      chk(pending == 1, "R1 software start sets pending", 64'(pending), 64'd1);
      wait_idle();
      chk(tcount == 2 && hw_en == 0, "R1 one transfer done", 64'({hw_en, tcount}), 64'd2);

      // R2: request ignored while disabled
      pulse_req();
      tick(5);
      chk(!pending && !busy && !err_flags[2] && tcount == 2, "R2 request ignored while disabled",
          64'({pending, busy, err_flags[2], tcount}), 64'd2);

      // R2/R4: hardware-triggered transfers to the end in single mode
      pulse_en();
      @(negedge clk);
      chk(hw_en == 1, "R2 enable set", 64'(hw_en), 64'd1);
      tick(0);
      pulse_req(); wait_idle();
      chk(tcount == 1, "R2 hardware request served", 64'(tcount), 64'd1);
      pulse_req(); wait_idle();
      chk(tcount == 0 && hw_en == 0, "R4 single mode auto-disable", 64'({hw_en, tcount}), 64'd0);
      chk(n_irq == 1, "R5 one irq per transaction", 64'(n_irq), 64'd1);

      // R3/R11: no transfer on zero count, reload re-arms
      pulse_sw();
      tick(6);
      chk(!busy && tcount == 0 && pending, "R3 no transfer at zero count",
          64'({busy, tcount, pending}), 64'd1);
      load(2, 32'h3000, 32'h4000, 8'h80, 8'h7F);
      wait_idle();
      chk(tcount == 1, "R11 reload re-arms pending request", 64'(tcount), 64'd1);
      pulse_sw(); wait_idle();
      chk(tcount == 0, "R3 count reaches zero", 64'(tcount), 64'd0);

      // R4: continuous mode keeps the enable flag
      cfg_cont_mode = 1;
      load(2, 32'hFFFF_FFF8, 32'h10, 8'd3, 8'd0);
      pulse_en();
      pulse_req(); wait_idle();
      pulse_req(); wait_idle();
      chk(hw_en == 1 && tcount == 0, "R4 continuous mode keeps enable", 64'({hw_en, tcount}), 64'h100);
      pulse_dis();
      @(negedge clk);
      chk(hw_en == 0, "R2 enable cleared", 64'(hw_en), 64'd0);
      tick(0);
      cfg_cont_mode = 0;

      // R10/R11: lost request and busy reload
      load(3, 32'h5000, 32'h6000, 8'd1, 8'd1);
      rdy_pct = 0;
      pulse_sw(); tick(2);
      pulse_sw();
      @(negedge clk);
      chk(err_flags[2] == 0 && pending, "R10 single queued request not lost", 64'({err_flags[2], pending}), 64'd1);
      tick(0);
      pulse_sw();
      @(negedge clk);
      chk(err_flags[2] == 1, "R10 lost request flagged", 64'(err_flags[2]), 64'd1);
      tick(0);
      cnt_init = 8'd9; cnt_load = 1; tick(1); cnt_load = 0;
      @(negedge clk);
      chk(tcount == 3, "R11 load ignored while busy", 64'(tcount), 64'd3);
      tick(0);
      rdy_pct = 100;
      wait_idle();
      chk(tcount == 1, "R10 queued request served", 64'(tcount), 64'd1);
      clear_flags(3'b100);
      @(negedge clk);
      chk(err_flags[2] == 0, "R10 lost flag cleared", 64'(err_flags[2]), 64'd0);
      tick(0);

      // R8: read error skips write, destination still moves
      force_rd_err = 1;
      load(1, 32'h7000, 32'h8000, 8'd3, 8'd5);
      n_wr = 0;
      pulse_sw(); wait_idle();
      chk(n_wr == 0, "R8 write skipped after read error", 64'(n_wr), 64'd0);
      chk(err_flags[0] == 1 && dst_addr == 32'h8014, "R8 read error flag and destination advance",
          64'({err_flags[0], dst_addr}), {31'd0, 1'b1, 32'h8014});
      force_rd_err = 0;
      clear_flags(3'b001);
      @(negedge clk);
      chk(err_flags[0] == 0, "R10 read error flag cleared", 64'(err_flags[0]), 64'd0);
      tick(0);

      // R9: write error
      force_wr_err = 1;
      load(1, 32'h9000, 32'hA000, 8'd1, 8'd1);
      pulse_sw(); wait_idle();
      chk(err_flags[1] == 1, "R9 write error flag", 64'(err_flags[1]), 64'd1);
      force_wr_err = 0;
      clear_flags(3'b010);

      // random phase
      void'($urandom(32'd1234));
      err_pct = 10;
      for (int it = 0; it < 150; it++) begin
         rdy_pct = 30 + int'($urandom % 71);
         if (tcount == 0) begin
            cfg_cont_mode = $urandom % 2;
            load(1 + int'($urandom % 4), $urandom, $urandom, SW'($urandom), SW'($urandom));
         end
         if ($urandom % 2) pulse_sw();
         else begin
            pulse_en();
            pulse_req();
         end
         wait_idle();
         if ($urandom % 4 == 0) clear_flags(3'($urandom));
      end
      err_pct = 0;
      rdy_pct = 100;
      tick(3);
      report();
   end

endmodule